// File: doc/BRIEF.md
# Block-Read Data Receiver for a Serial Memory Card Host

This block sits on the host side of a memory card link and receives read data arriving on one data line. The command sequencer pulses a start input right after the end bit of a read command has gone out. From then on the receiver counts bit strobes while it waits out the card's access delay. It ignores the idle and pulled-high levels on the line until the first 0, which is the start bit. It then shifts in one block of the configured length, checks the 16-bit check word, and checks the end bit that follows it.

Each received byte goes out on a valid/ready byte stream. After the end bit of every block the receiver gives a one-cycle done pulse, together with an error flag for that block. In single-block mode it then goes idle. In multi-block mode it goes back to waiting for the next start bit and keeps doing so until the sequencer reports that a stop command was issued. A watchdog on the access delay ends the wait with a timeout pulse when no start bit comes.

Top module: `card_rd_rx`

## Requirements
- R1: After reset, busy, outValid, blkDone and timeout are low. A startRd pulse while idle latches blkLen and multiBlk and raises busy on the next cycle. startRd has no effect while busy.
- R2: datIn is sampled only in cycles where bitStb is high. While waiting, sampled 1s are ignored and the first sampled 0 is taken as the start bit.
- R3: After the start bit the receiver collects exactly blkLen bytes (blkLen at least 1). Each byte is eight sampled bits, most significant bit first.
- R4: The check word is CRC-16 with generator 0x1021, initial value 0, computed over the data bits in line order. It follows the data as 16 bits, most significant bit first, and is followed by one end bit that must be 1.
- R5: One cycle after the end bit is sampled, blkDone is high for exactly one cycle. crcErr is valid in that cycle and is 1 when the check word mismatches or the end bit is 0.
- R6: While waiting, a start bit is accepted on any of the first nacMax bit strobes. If the nacMax-th strobe still samples 1, timeout pulses for one cycle and the receiver goes idle.
- R7: In single-block mode the receiver is idle (busy low) after the end bit.
- R8: In multi-block mode, after each end bit the receiver waits for the next start bit with a fresh access-delay count, and it keeps doing so until stopped.
- R9: A stopReq pulse while busy aborts reception at the next bit strobe. That bit is discarded, the receiver goes idle, and no further bytes and no blkDone are produced. stopReq while idle has no effect.
- R10: A completed byte stays on outData with outValid high until outReady is seen high. The consumer must accept each byte before the next byte is complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startRd | input | 1 | Pulse: read command end bit has been sent |
| multiBlk | input | 1 | 1 = multi-block transfer, 0 = single block |
| blkLen | input | LEN_W | Block length in bytes, at least 1 |
| nacMax | input | NAC_W | Maximum bit strobes to wait for a start bit |
| stopReq | input | 1 | Pulse: stop command issued, end reception |
| bitStb | input | 1 | Bit boundary strobe; datIn is sampled when high |
| datIn | input | 1 | Data line level |
| outData | output | 8 | Received byte |
| outValid | output | 1 | outData holds an unaccepted byte |
| outReady | input | 1 | Consumer accepts the byte |
| busy | output | 1 | A transfer is in progress |
| blkDone | output | 1 | One-cycle pulse after each end bit |
| crcErr | output | 1 | Block error flag, valid with blkDone |
| timeout | output | 1 | One-cycle pulse: no start bit within nacMax strobes |

## Verification
The assertions rely on the consumer taking each byte within the eight bit strobes that the next byte needs. They also rely on blkLen being nonzero and stable for the whole transfer. The bench meets both. Bit strobes come every third clock, and outReady is held low for at most two cycles out of five, so a stall never spans a byte. Every transfer is started with a block length of one or more, and stop pulses are placed only between bit strobes.

// File: rtl/card_rd_pkg.sv
package card_rd_pkg;

  localparam logic [15:0] CRC_GEN = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_CRC,
    ST_END
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic crcClr;    // start bit seen: clear shift and check registers
    logic shiftEn;   // consume one data or check bit
    logic byteLoad;  // eighth bit of a byte: publish it
    logic endChk;    // end bit: evaluate the block
  } dpStrobe_t;

endpackage

// File: rtl/card_rd_ctrl.sv
module card_rd_ctrl
  import card_rd_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int NAC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startRd,
  input  logic             multiBlk,
  input  logic [LEN_W-1:0] blkLen,
  input  logic [NAC_W-1:0] nacMax,
  input  logic             stopReq,
  input  logic             bitStb,
  input  logic             datIn,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             timeout
);

  localparam int CRC_BITS = 16;
  localparam int CCNT_W   = $clog2(CRC_BITS);

  rxState_e          state;
  logic [LEN_W-1:0]  lenLat;
  logic [LEN_W-1:0]  byteCnt;
  logic [NAC_W-1:0]  nacCnt;
  logic [2:0]        bitCnt;
  logic [CCNT_W-1:0] crcCnt;
  logic              multiLat;
  logic              stopPend;

  logic             abortNow;
  logic [NAC_W:0]   nacNext;
  logic             nacHit;
  logic [LEN_W-1:0] lenLast;

  assign busy     = (state != ST_IDLE);
  assign abortNow = busy && bitStb && (stopReq || stopPend);
  assign nacNext  = {1'b0, nacCnt} + {{NAC_W{1'b0}}, 1'b1};
  assign nacHit   = (nacNext >= {1'b0, nacMax});
  assign lenLast  = lenLat - {{(LEN_W-1){1'b0}}, 1'b1};

  always_comb begin
    strobe = '0;
    if (bitStb && !abortNow) begin
      unique case (state)
        ST_WAIT: strobe.crcClr = !datIn;
        ST_DATA: begin
          strobe.shiftEn  = 1'b1;
          strobe.byteLoad = (bitCnt == 3'd7);
        end
        ST_CRC:  strobe.shiftEn = 1'b1;
        ST_END:  strobe.endChk  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lenLat   <= '0;
      byteCnt  <= '0;
      nacCnt   <= '0;
      bitCnt   <= '0;
      crcCnt   <= '0;
      multiLat <= 1'b0;
      stopPend <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (state == ST_IDLE) begin
        stopPend <= 1'b0;
        if (startRd) begin
          lenLat   <= blkLen;
          multiLat <= multiBlk;
          nacCnt   <= '0;
          state    <= ST_WAIT;
        end
      end else if (abortNow) begin
        state    <= ST_IDLE;
        stopPend <= 1'b0;
      end else begin
        if (stopReq) stopPend <= 1'b1;
        if (bitStb) begin
          unique case (state)
            ST_WAIT: begin
              if (!datIn) begin
                state   <= ST_DATA;
                bitCnt  <= '0;
                byteCnt <= '0;
              end else if (nacHit) begin
                timeout <= 1'b1;
                state   <= ST_IDLE;
              end else begin
                nacCnt <= nacNext[NAC_W-1:0];
              end
            end
            ST_DATA: begin
              bitCnt <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) begin
                if (byteCnt == lenLast) begin
                  state  <= ST_CRC;
                  crcCnt <= '0;
                end else begin
                  byteCnt <= byteCnt + {{(LEN_W-1){1'b0}}, 1'b1};
                end
              end
            end
            ST_CRC: begin
              crcCnt <= crcCnt + {{(CCNT_W-1){1'b0}}, 1'b1};
              if (crcCnt == CCNT_W'(CRC_BITS - 1)) state <= ST_END;
            end
            ST_END: begin
              if (multiLat) begin
                state  <= ST_WAIT;
                nacCnt <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R1: a transfer only starts on request
  assert_start_on_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startRd));

  // R3: byte index stays inside the block
  assert_byte_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (byteCnt < lenLat));

  // R6: a timeout leaves the receiver idle
  assert_timeout_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> !busy);

  // R7: a single-block transfer ends after its end bit
  assert_single_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.endChk && !multiLat) |=> !busy);

  // R9: a stop at a bit boundary ends reception
  assert_stop_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    abortNow |=> (!busy && !timeout));

endmodule

// File: rtl/card_rd_dpath.sv
module card_rd_dpath
  import card_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       datIn,
  input  logic       outReady,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       blkDone,
  output logic       crcErr
);

  logic [6:0]  shReg;
  logic [15:0] crcReg;
  logic [15:0] crcStep;

  // one step of the serial check-word division
  assign crcStep = {crcReg[14:0], 1'b0} ^ ((crcReg[15] ^ datIn) ? CRC_GEN : 16'h0000);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      crcReg   <= '0;
      outData  <= '0;
      outValid <= 1'b0;
      blkDone  <= 1'b0;
      crcErr   <= 1'b0;
    end else begin
      blkDone <= 1'b0;
      if (strobe.crcClr) begin
        shReg  <= '0;
        crcReg <= '0;
      end else if (strobe.shiftEn) begin
        shReg  <= {shReg[5:0], datIn};
        crcReg <= crcStep;
      end
      if (strobe.byteLoad) begin
        outData  <= {shReg, datIn};
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      if (strobe.endChk) begin
        blkDone <= 1'b1;
        crcErr  <= (crcReg != 16'h0000) || !datIn;
      end
    end
  end

  // R10: a new byte never lands on an unaccepted one
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteLoad |-> !(outValid && !outReady));

  // R5: the done pulse lasts one cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    blkDone |=> !blkDone);

endmodule

// File: rtl/card_rd_rx.sv
module card_rd_rx
  import card_rd_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int NAC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startRd,
  input  logic             multiBlk,
  input  logic [LEN_W-1:0] blkLen,
  input  logic [NAC_W-1:0] nacMax,
  input  logic             stopReq,
  input  logic             bitStb,
  input  logic             datIn,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             busy,
  output logic             blkDone,
  output logic             crcErr,
  output logic             timeout
);

  dpStrobe_t strobe;

  card_rd_ctrl #(.LEN_W(LEN_W), .NAC_W(NAC_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startRd (startRd),
    .multiBlk(multiBlk),
    .blkLen  (blkLen),
    .nacMax  (nacMax),
    .stopReq (stopReq),
    .bitStb  (bitStb),
    .datIn   (datIn),
    .strobe  (strobe),
    .busy    (busy),
    .timeout (timeout)
  );

  card_rd_dpath uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .datIn   (datIn),
    .outReady(outReady),
    .outData (outData),
    .outValid(outValid),
    .blkDone (blkDone),
    .crcErr  (crcErr)
  );

endmodule

// File: tb/tb_card_rd_rx.sv
module tb_card_rd_rx;

  localparam int LEN_W = 12;
  localparam int NAC_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startRd = 1'b0;
  logic             multiBlk = 1'b0;
  logic [LEN_W-1:0] blkLen = '0;
  logic [NAC_W-1:0] nacMax = '0;
  logic             stopReq = 1'b0;
  logic             bitStb = 1'b0;
  logic             datIn = 1'b1;
  logic [7:0]       outData;
  logic             outValid;
  logic             outReady = 1'b1;
  logic             busy;
  logic             blkDone;
  logic             crcErr;
  logic             timeout;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit stallOn = 0;
  int stallCnt = 0;

  logic [7:0] byteQ[$];
  int         statQ[$];   // 0 good block, 1 bad block, 2 timeout

  always #5 clk = ~clk;

  card_rd_rx #(.LEN_W(LEN_W), .NAC_W(NAC_W)) dut (
    .clk(clk), .rstN(rstN), .startRd(startRd), .multiBlk(multiBlk),
    .blkLen(blkLen), .nacMax(nacMax), .stopReq(stopReq), .bitStb(bitStb),
    .datIn(datIn), .outData(outData), .outValid(outValid), .outReady(outReady),
    .busy(busy), .blkDone(blkDone), .crcErr(crcErr), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // consumer: stalls at most two cycles in five (R10)
  always @(posedge clk) begin
    stallCnt <= (stallCnt + 1) % 5;
    outReady <= !stallOn || (stallCnt >= 2);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid && outReady) begin
        if (byteQ.size() == 0) chk(0, "R3 unexpected byte", int'(outData), -1);
        else begin
          logic [7:0] e;
          e = byteQ.pop_front();
          chk(outData == e, "R3 byte value", int'(outData), int'(e));
        end
      end
      if (blkDone) begin
        if (statQ.size() == 0) chk(0, "R5 unexpected blkDone", 1, 0);
        else begin
          int s;
          s = statQ.pop_front();
          chk(int'(crcErr) == s, "R5 crcErr", int'(crcErr), s);
        end
      end
      if (timeout) begin
        if (statQ.size() == 0) chk(0, "R6 unexpected timeout", 1, 0);
        else begin
          int s;
          s = statQ.pop_front();
          chk(s == 2, "R6 timeout event", 2, s);
        end
      end
    end
  end

  function automatic logic [15:0] crcBit(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  // one bit per three clocks; non-strobe cycles carry a 0 that must be ignored (R2)
  task automatic sendBit(input logic b);
    @(negedge clk);
    datIn  = b;
    bitStb = 1'b1;
    @(negedge clk);
    bitStb = 1'b0;
    datIn  = 1'b0;
    @(negedge clk);
  endtask

  task automatic startRead(input int len, input bit multi, input int nac);
    @(negedge clk);
    blkLen   = LEN_W'(len);
    multiBlk = multi;
    nacMax   = NAC_W'(nac);
    startRd  = 1'b1;
    @(negedge clk);
    startRd = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
  endtask

  task automatic sendByte(input logic [7:0] v, inout logic [15:0] c, input bit expectIt);
    if (expectIt) byteQ.push_back(v);
    for (int i = 7; i >= 0; i--) begin
      c = crcBit(c, v[i]);
      sendBit(v[i]);
    end
  endtask

  task automatic sendBlock(input int len, input int pre, input bit badCrc, input bit badEnd);
    logic [15:0] c;
    logic [15:0] tx;
    c = '0;
    for (int i = 0; i < pre; i++) sendBit(1'b1);
    sendBit(1'b0);
    for (int i = 0; i < len; i++) sendByte(8'($urandom), c, 1'b1);
    tx = c ^ (badCrc ? 16'h0100 : 16'h0000);
    statQ.push_back((badCrc || badEnd) ? 1 : 0);
    for (int i = 15; i >= 0; i--) sendBit(tx[i]);
    sendBit(badEnd ? 1'b0 : 1'b1);
  endtask

  task automatic idleCheck(input string req);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, req, int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0, "R1 reset busy", int'(busy), 0);
    chk(outValid == 0, "R1 reset outValid", int'(outValid), 0);
    chk(blkDone == 0 && timeout == 0, "R1 reset pulses", int'(blkDone | timeout), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9: stop while idle has no effect; R2/R3/R4/R7 single block
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    startRead(4, 0, 8);
    sendBlock(4, 3, 0, 0);
    idleCheck("R7 idle after single block");

    // R2: start bit on the very first strobe, one-byte block
    startRead(1, 0, 8);
    sendBlock(1, 0, 0, 0);
    idleCheck("R7 idle after one-byte block");

    // R4/R5: corrupted check word, then bad end bit
    startRead(3, 0, 8);
    sendBlock(3, 1, 1, 0);
    idleCheck("R5 idle after bad check word");
    startRead(2, 0, 8);
    sendBlock(2, 2, 0, 1);
    idleCheck("R5 idle after bad end bit");

    // R6: start bit on the last allowed strobe is accepted
    startRead(2, 0, 5);
    sendBlock(2, 4, 0, 0);
    idleCheck("R6 idle after boundary block");
    // R6: all strobes high -> timeout
    startRead(2, 0, 5);
    statQ.push_back(2);
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    idleCheck("R6 idle after timeout");
    // R1: start bit after timeout produces nothing
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(1'b1);

    // R8/R10: multi-block with consumer stalls, then stop while waiting (R9)
    stallOn = 1;
    startRead(3, 1, 8);
    sendBlock(3, 2, 0, 0);
    sendBlock(3, 0, 0, 0);
    sendBlock(3, 5, 0, 0);
    chk(busy == 1'b1, "R8 still busy between blocks", int'(busy), 1);
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    sendBit(1'b1);
    idleCheck("R9 idle after stop while waiting");
    sendBit(1'b0);
    for (int i = 0; i < 10; i++) sendBit(1'b0);
    stallOn = 0;

    // R9: stop in the middle of a block
    begin
      logic [15:0] c;
      c = '0;
      startRead(4, 1, 8);
      sendBit(1'b1);
      sendBit(1'b0);
      sendByte(8'hA5, c, 1'b1);
      sendByte(8'h3C, c, 1'b1);
      sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
      stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
      chk(busy == 1'b1, "R9 busy until next strobe", int'(busy), 1);
      for (int i = 0; i < 30; i++) sendBit(i[0]);
      idleCheck("R9 idle after mid-block stop");
    end

    repeat (20) @(negedge clk);
    chk(byteQ.size() == 0, "R3 all bytes delivered", byteQ.size(), 0);
    chk(statQ.size() == 0, "R5 all block events seen", statQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule